// File: doc/BRIEF.md
# System Control Port Register File

This block is a small bank of byte-wide control and identification ports on a plain I/O bus. A bus master presents an address with a write or read strobe. The block decodes a fixed set of port addresses. Some ports hold control state that drives output pins: a soft-reset level, a byte-order mode, an indicator light and an I/O map selection. Some ports return constant board identification and status bytes. Two ports emit a one-cycle pulse that toggles the lock of an external nonvolatile memory.

Read data is registered and appears one cycle after the read strobe. It then holds until the next read. An access that the decoder does not accept for its direction returns the all-ones byte (for a read) and raises a one-cycle error strobe. Such an access changes no state.

Top module: `sysctl_regfile`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, soft_reset, little_endian, light_on, map_contig, lock_pulse, bus_err and bus_rdata are all zero.
- R2: A write to port 0x0092 sets soft_reset to data bit 0 and little_endian to data bit 1. Both outputs take the new values in the cycle after the write strobe. A read of 0x0092 returns 0x02 when little_endian is 1 and 0x00 when it is 0. The soft-reset level is not visible in the read value.
- R3: Reads of ports 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these three ports are accepted without error and change no state.
- R4: Reads of ports 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to port 0x0808 sets light_on to data bit 0, in the cycle after the strobe.
- R6: A write to 0x0810 raises lock_pulse bit 0 for exactly the next cycle. A write to 0x0812 raises lock_pulse bit 1 for exactly the next cycle. The write data has no effect, and at most one bit of lock_pulse is high at any time.
- R7: A write to port 0x081C stores data bits 3:0. A read of 0x081C returns the stored nibble in bits 3:0, with bits 7:4 zero.
- R8: A write to port 0x0850 stores data bit 0, which map_contig outputs from the next cycle. A read of 0x0850 returns 0x01 or 0x00 to match.
- R9: A read of any port not listed in R2 to R8 returns 0xFF. Port 0x0814 reads 0xFF without error, and writes to it are accepted without error and ignored.
- R10: bus_err is high for one cycle, the cycle after the strobe, for any of these accesses: a read of an address outside 0x0092, 0x0800, 0x0802, 0x0803, 0x080C, 0x0810, 0x0814, 0x0818, 0x081C, 0x0823, 0x0850; or a write to an address outside 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C, 0x0850. Such a write changes no state.
- R11: bus_rdata takes the read value in the cycle after the read strobe and holds it while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Port address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| bus_err | output | 1 | One-cycle strobe for an access that the decoder does not accept |
| soft_reset | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Byte-order mode flag |
| light_on | output | 1 | Indicator light state |
| map_contig | output | 1 | I/O map type flag |
| lock_pulse | output | LOCK_N (2) | One-cycle lock-toggle pulses, bit 0 for channel 1, bit 1 for channel 2 |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data, a 4-bit control nibble and two lock channels. The address is decoded in full, so random addresses across the whole 16-bit space reach near-miss addresses such as 0x8092 or 0x0801. A decoder that ignores the upper address bits then shows up as a wrong read value or a missing error strobe. With an 8-bit data bus, random write bytes with high bits set check that the control nibble and the single-bit flags store only the bits they own.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [3:0] {
    PS_SPECIAL, PS_CPUID, PS_FEAT, PS_STAT, PS_LIGHT, PS_EQUIP, PS_XFEAT,
    PS_LOCKB, PS_L2INV, PS_KEY, PS_SYSCTL, PS_CACHE, PS_MAP, PS_NONE
  } port_e;

  localparam int unsigned A_SPECIAL = 32'h0092;
  localparam int unsigned A_CPUID   = 32'h0800;
  localparam int unsigned A_FEAT    = 32'h0802;
  localparam int unsigned A_STAT    = 32'h0803;
  localparam int unsigned A_LIGHT   = 32'h0808;
  localparam int unsigned A_EQUIP   = 32'h080C;
  localparam int unsigned A_XFEAT   = 32'h0810;
  localparam int unsigned A_LOCKB   = 32'h0812;
  localparam int unsigned A_L2INV   = 32'h0814;
  localparam int unsigned A_KEY     = 32'h0818;
  localparam int unsigned A_SYSCTL  = 32'h081C;
  localparam int unsigned A_CACHE   = 32'h0823;
  localparam int unsigned A_MAP     = 32'h0850;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LOCK_N = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             sel,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [LOCK_N-1:0] lock_hit
);

  always_comb begin
    case (addr)
      ADDR_W'(A_SPECIAL): sel = PS_SPECIAL;
      ADDR_W'(A_CPUID):   sel = PS_CPUID;
      ADDR_W'(A_FEAT):    sel = PS_FEAT;
      ADDR_W'(A_STAT):    sel = PS_STAT;
      ADDR_W'(A_LIGHT):   sel = PS_LIGHT;
      ADDR_W'(A_EQUIP):   sel = PS_EQUIP;
      ADDR_W'(A_XFEAT):   sel = PS_XFEAT;
      ADDR_W'(A_LOCKB):   sel = PS_LOCKB;
      ADDR_W'(A_L2INV):   sel = PS_L2INV;
      ADDR_W'(A_KEY):     sel = PS_KEY;
      ADDR_W'(A_SYSCTL):  sel = PS_SYSCTL;
      ADDR_W'(A_CACHE):   sel = PS_CACHE;
      ADDR_W'(A_MAP):     sel = PS_MAP;
      default:            sel = PS_NONE;
    endcase
  end

  // Readable and writable port sets differ: some ports exist in one direction only.
  always_comb begin
    rd_ok = !(sel inside {PS_LIGHT, PS_LOCKB, PS_NONE});
    wr_ok = !(sel inside {PS_EQUIP, PS_KEY, PS_CACHE, PS_NONE});
  end

  // Lock channel i belongs to the i-th lock port.
  generate
    for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
      if (i == 0) begin : g_first
        assign lock_hit[i] = (sel == PS_XFEAT);
      end else if (i == 1) begin : g_second
        assign lock_hit[i] = (sel == PS_LOCKB);
      end else begin : g_spare
        assign lock_hit[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4,
  parameter int LOCK_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  port_e             sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LOCK_N-1:0] lock_hit,
  output logic              soft_reset,
  output logic              little_endian,
  output logic              light_on,
  output logic [CTL_W-1:0]  ctl_nib,
  output logic              map_contig,
  output logic [LOCK_N-1:0] lock_pulse
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_reset    <= 1'b0;
      little_endian <= 1'b0;
      light_on      <= 1'b0;
      ctl_nib       <= '0;
      map_contig    <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        PS_SPECIAL: begin
          soft_reset    <= wdata[0];
          little_endian <= wdata[1];
        end
        PS_LIGHT:  light_on   <= wdata[0];
        PS_SYSCTL: ctl_nib    <= wdata[CTL_W-1:0];
        PS_MAP:    map_contig <= wdata[0];
        default: ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < LOCK_N; i++) begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) lock_pulse[i] <= 1'b0;
        else     lock_pulse[i] <= wr_en & lock_hit[i];
      end
    end
  endgenerate

  // R2 R5 R7 R8: control state moves only after a write strobe
  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(soft_reset) && $stable(little_endian)
                       && $stable(light_on) && $stable(ctl_nib) && $stable(map_contig)));

  // R6: never two lock channels at once
  assert_lock_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lock_pulse));

  // R6: a pulse follows a write strobe
  assert_lock_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_pulse != '0) |-> $past(wr_en));

endmodule

// File: rtl/sysctl_readback.sv
module sysctl_readback
  import sysctl_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          CTL_W    = 4,
  parameter logic [7:0]  ID_CPU   = 8'hEF,
  parameter logic [7:0]  ID_FEAT  = 8'hAD,
  parameter logic [7:0]  ID_STAT  = 8'hE0,
  parameter logic [7:0]  ST_EQUIP = 8'h3C,
  parameter logic [7:0]  ST_XFEAT = 8'h39,
  parameter logic [7:0]  ST_KEY   = 8'h00,
  parameter logic [7:0]  ST_CACHE = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  port_e             sel,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic              little_endian,
  input  logic [CTL_W-1:0]  ctl_nib,
  input  logic              map_contig,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);

  localparam logic [DATA_W-1:0] RD_DEFAULT = '1;

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    case (sel)
      PS_SPECIAL: rd_val = DATA_W'({little_endian, 1'b0});
      PS_CPUID:   rd_val = DATA_W'(ID_CPU);
      PS_FEAT:    rd_val = DATA_W'(ID_FEAT);
      PS_STAT:    rd_val = DATA_W'(ID_STAT);
      PS_EQUIP:   rd_val = DATA_W'(ST_EQUIP);
      PS_XFEAT:   rd_val = DATA_W'(ST_XFEAT);
      PS_KEY:     rd_val = DATA_W'(ST_KEY);
      PS_SYSCTL:  rd_val = DATA_W'(ctl_nib);
      PS_CACHE:   rd_val = DATA_W'(ST_CACHE);
      PS_MAP:     rd_val = DATA_W'(map_contig);
      default:    rd_val = RD_DEFAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      err <= (rd_en & !rd_ok) | (wr_en & !wr_ok);
    end
  end

  // R11: read data holds between read strobes
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));

  // R10: error strobe only follows an access
  assert_err_after_access_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(rd_en) || $past(wr_en)));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4,
  parameter int LOCK_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              soft_reset,
  output logic              little_endian,
  output logic              light_on,
  output logic              map_contig,
  output logic [LOCK_N-1:0] lock_pulse
);

  port_e             sel;
  logic              rd_ok;
  logic              wr_ok;
  logic [LOCK_N-1:0] lock_hit;
  logic [CTL_W-1:0]  ctl_nib;

  sysctl_decode #(.ADDR_W(ADDR_W), .LOCK_N(LOCK_N)) u_dec (
    .addr(bus_addr), .sel(sel), .rd_ok(rd_ok), .wr_ok(wr_ok), .lock_hit(lock_hit)
  );

  sysctl_ctrl #(.DATA_W(DATA_W), .CTL_W(CTL_W), .LOCK_N(LOCK_N)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
    .lock_hit(lock_hit), .soft_reset(soft_reset), .little_endian(little_endian),
    .light_on(light_on), .ctl_nib(ctl_nib), .map_contig(map_contig),
    .lock_pulse(lock_pulse)
  );

  sysctl_readback #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_rb (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .wr_en(bus_wr), .sel(sel),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .little_endian(little_endian),
    .ctl_nib(ctl_nib), .map_contig(map_contig), .rdata(bus_rdata), .err(bus_err)
  );

  // R1: outputs at rest out of reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0 && !bus_err && !soft_reset && lock_pulse == '0));

endmodule

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic        soft_reset, little_endian, light_on, map_contig;
  logic [1:0]  lock_pulse;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic       m_sr, m_le, m_light, m_map;
  logic [3:0] m_ctl;

  always #2 clk = ~clk;

  sysctl_regfile uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .soft_reset(soft_reset), .little_endian(little_endian), .light_on(light_on),
    .map_contig(map_contig), .lock_pulse(lock_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic [15:0] a, input bit is_wr);
    if (is_wr)
      case (a)
        16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
        16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b0;
        default: return 1'b1;
      endcase
    else
      case (a)
        16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810,
        16'h0814, 16'h0818, 16'h081C, 16'h0823, 16'h0850: return 1'b0;
        default: return 1'b1;
      endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h0092: return {6'b0, m_le, 1'b0};
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h081C: return {4'b0, m_ctl};
      16'h0823: return 8'h03;
      16'h0850: return {7'b0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " R2 soft_reset"}, soft_reset, m_sr);
    chk({tag, " R2 little_endian"}, little_endian, m_le);
    chk({tag, " R5 light_on"}, light_on, m_light);
    chk({tag, " R8 map_contig"}, map_contig, m_map);
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    logic [1:0] exp_lock;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      16'h0092: begin m_sr = d[0]; m_le = d[1]; end
      16'h0808: m_light = d[0];
      16'h081C: m_ctl = d[3:0];
      16'h0850: m_map = d[0];
      default: ;
    endcase
    exp_lock = (a == 16'h0810) ? 2'b01 : (a == 16'h0812) ? 2'b10 : 2'b00;
    chk({tag, " R10 err"}, bus_err, exp_err(a, 1'b1));
    chk({tag, " R6 lock"}, lock_pulse, exp_lock);
    check_state(tag);
  endtask

  task automatic do_rd(input logic [15:0] a, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk({tag, " R11 rdata"}, bus_rdata, exp_rd(a));
    chk({tag, " R10 err"}, bus_err, exp_err(a, 1'b0));
    chk({tag, " R6 no lock"}, lock_pulse, 2'b00);
  endtask

  initial begin
    logic [15:0] pool [16];
    logic [7:0]  held;
    pool = '{16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h080C,
             16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C, 16'h0823,
             16'h0850, 16'h8092, 16'h0801, 16'h0000};
    m_sr = 0; m_le = 0; m_light = 0; m_map = 0; m_ctl = 0;
    void'($urandom(32'h5EED_0C11));

    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    chk("R1 err in reset", bus_err, 1'b0);
    chk("R1 lock in reset", lock_pulse, 2'b00);
    check_state("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    check_state("R1 after reset");

    // Directed corner cases
    do_wr(16'h0092, 8'h03, "R2 both bits");
    do_rd(16'h0092, "R2 read special");
    do_wr(16'h0092, 8'hFD, "R2 reset only");
    do_rd(16'h0092, "R2 read special le0");
    do_rd(16'h0800, "R3 cpu id");
    do_rd(16'h0802, "R3 feature id");
    do_rd(16'h0803, "R3 status id");
    do_wr(16'h0800, 8'h00, "R3 id write ignored");
    do_rd(16'h0800, "R3 id after write");
    do_rd(16'h080C, "R4 equip");
    do_rd(16'h0810, "R4 xfeat");
    do_rd(16'h0818, "R4 key");
    do_rd(16'h0823, "R4 cache");
    do_wr(16'h0808, 8'hFF, "R5 light on");
    do_wr(16'h0808, 8'hFE, "R5 light off");
    do_wr(16'h0810, 8'h00, "R6 lock one");
    @(negedge clk);
    chk("R6 pulse one cycle", lock_pulse, 2'b00);
    do_wr(16'h0812, 8'hFF, "R6 lock two");
    do_wr(16'h081C, 8'hFF, "R7 nibble");
    do_rd(16'h081C, "R7 read nibble");
    do_wr(16'h0850, 8'hFF, "R8 map set");
    do_rd(16'h0850, "R8 read map");
    do_rd(16'h0814, "R9 l2inv read");
    do_wr(16'h0814, 8'hFF, "R9 l2inv write");
    do_rd(16'h1234, "R9 unlisted read");
    do_rd(16'h0808, "R10 write-only port read");
    do_wr(16'h080C, 8'hFF, "R10 read-only port write");
    do_wr(16'h8850, 8'h00, "R10 alias write");
    do_rd(16'h0850, "R10 map kept");
    held = bus_rdata;
    @(negedge clk);
    chk("R11 rdata held", bus_rdata, held);
    chk("R10 err one cycle", bus_err, 1'b0);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned k;
      logic [15:0] a;
      k = $urandom % 16;
      a = (k == 15) ? 16'($urandom) : pool[k];
      if ($urandom % 2) do_wr(a, 8'($urandom), "rand wr");
      else              do_rd(a, "rand rd");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule